// File: doc/BRIEF.md
# Data Value Compare Byte Combiner

This block watches a 32-bit data bus and, for each of two independent comparators, decides whether the bus value matches a programmed compare value. The comparison is split into four byte lanes. Each lane yields its own equality result, and a per-comparator byte-enable mask picks which lanes take part. A 2-bit mode then merges the enabled lane results into one verdict. The verdict can require all enabled lanes to match, any one enabled lane to match, or at least one of two lane pairs to match in full.

Both comparators take their modes and enables from one shared 32-bit control word. Each has its own compare value. A qualifying valid strobe marks the bus cycles to evaluate. Each comparator drives a registered match pulse that is high for one cycle after a qualifying cycle whose data satisfied its rule.

Top module: `dvc_pair`

## Requirements
- R1: Byte lane 0 is bus bits 31:24, lane 1 is bits 23:16, lane 2 is bits 15:8 and lane 3 is bits 7:0. A lane matches when all eight of its data bits equal the same eight bits of the comparator's compare value.
- R2: Mode 2'b01 (all) matches when at least one lane is enabled and every enabled lane matches.
- R3: Mode 2'b10 (any) matches when at least one enabled lane matches.
- R4: Mode 2'b11 (pairs) matches when the pair of lanes 0 and 1 matches, or the pair of lanes 2 and 3 matches. A pair matches when at least one of its lanes is enabled and every enabled lane in it matches. A pair with neither lane enabled never matches.
- R5: With an all-zero byte-enable mask, a comparator never matches in any mode.
- R6: Mode 2'b00 is reserved and never produces a match.
- R7: A match output goes high in the cycle after a clock edge where valid was high and the rule was met, and it stays high for that one cycle only. It is low after any cycle with valid low and while reset (active-low, synchronous) is applied.
- R8: The control word (bit 0 = LSB) holds the following fields. Comparator A mode is in bits 19:18 and comparator B mode is in bits 17:16, with the upper bit of each the mode's MSB. Comparator A enables are in bits 11:8 and comparator B enables are in bits 3:0. In each enable field, the highest bit enables lane 0 and the lowest bit enables lane 3.
- R9: The two comparators evaluate the same bus cycle independently, each using its own compare value, mode and enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 32 | Observed bus data |
| bus_valid | input | 1 | Qualifies bus_data for this cycle |
| cmp_val_a | input | 32 | Compare value of comparator A |
| cmp_val_b | input | 32 | Compare value of comparator B |
| ctrl_word | input | 32 | Shared mode and byte-enable fields |
| match_a | output | 1 | Registered match pulse of comparator A |
| match_b | output | 1 | Registered match pulse of comparator B |

## Verification
The bench sweeps every mode, every enable mask and every pattern of lane hits for both comparators at once, and gives comparator B a different mode, mask and hit pattern each time. The sweep catches the following faults:
- A design that reverses lane order or the enable bit order misses the lane-specific mismatches.
- A design that treats disabled lanes as matching inside the any rule fires with mismatching data.
- A design that lets an empty mask or an empty pair count as "all matched" fires on an all-zero or half-zero mask.
- A design that lets reserved mode through fires where none is expected.
- A design that leaks through while valid is low fires on the interleaved idle cycles.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

  localparam int DVC_LANES = 4;

  typedef enum logic [1:0] {
    DVC_RSV  = 2'b00,
    DVC_ALL  = 2'b01,
    DVC_ANY  = 2'b10,
    DVC_PAIR = 2'b11
  } dvc_mode_e;

  // Lanes outside the mask are neutral in an AND: forced true.
  function automatic logic [DVC_LANES-1:0] and_view(
    input logic [DVC_LANES-1:0] hit, input logic [DVC_LANES-1:0] en);
    return hit | ~en;
  endfunction

  // Lanes outside the mask are neutral in an OR: forced false.
  function automatic logic [DVC_LANES-1:0] or_view(
    input logic [DVC_LANES-1:0] hit, input logic [DVC_LANES-1:0] en);
    return hit & en;
  endfunction

  // A group matches only if it has a member enabled and all enabled members hit.
  function automatic logic group_all(input logic [1:0] hit, input logic [1:0] en);
    return (|en) && (&(hit | ~en));
  endfunction

endpackage

// File: rtl/dvc_lane_cmp.sv
module dvc_lane_cmp #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] data,
  input  logic [LANES*BYTE_W-1:0] ref_val,
  output logic [LANES-1:0]        lane_hit
);
  localparam int W = LANES * BYTE_W;

  // Lane 0 is the most significant byte.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int TOP = W - 1 - g * BYTE_W;
    assign lane_hit[g] = (data[TOP -: BYTE_W] == ref_val[TOP -: BYTE_W]);
  end

endmodule

// File: rtl/dvc_combine.sv
module dvc_combine
  import dvc_pkg::*;
(
  input  logic [1:0]           mode,
  input  logic [DVC_LANES-1:0] en,
  input  logic [DVC_LANES-1:0] lane_hit,
  output logic                 hit
);
  logic any_en;
  logic all_ok;
  logic any_ok;
  logic pair_lo;
  logic pair_hi;
  dvc_mode_e m;

  assign m       = dvc_mode_e'(mode);
  assign any_en  = |en;
  assign all_ok  = any_en && (&and_view(lane_hit, en));
  assign any_ok  = |or_view(lane_hit, en);
  assign pair_lo = group_all(lane_hit[1:0], en[1:0]);
  assign pair_hi = group_all(lane_hit[3:2], en[3:2]);

  always_comb begin
    unique case (m)
      DVC_ALL:  hit = all_ok;
      DVC_ANY:  hit = any_ok;
      DVC_PAIR: hit = pair_lo | pair_hi;
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    // R2
    all_mode_chk: assert (!(m == DVC_ALL && hit) || ((lane_hit & en) == en && en != '0));
    // R3
    any_mode_chk: assert (!(m == DVC_ANY && hit) || ((lane_hit & en) != '0));
    // R5
    empty_mask_chk: assert (en != '0 || !hit);
  end

endmodule

// File: rtl/dvc_unit.sv
module dvc_unit
  import dvc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int W = DVC_LANES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [W-1:0]         data,
  input  logic [W-1:0]         ref_val,
  input  logic [1:0]           mode,
  input  logic [DVC_LANES-1:0] en,
  output logic                 match
);
  logic [DVC_LANES-1:0] lane_hit;
  logic                 comb_hit;
  logic                 match_q;

  dvc_lane_cmp #(.LANES(DVC_LANES), .BYTE_W(BYTE_W)) cmp_i (
    .data     (data),
    .ref_val  (ref_val),
    .lane_hit (lane_hit)
  );

  dvc_combine comb_i (
    .mode     (mode),
    .en       (en),
    .lane_hit (lane_hit),
    .hit      (comb_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= valid & comb_hit;
  end

  assign match = match_q;

  // R7
  pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> $past(valid));
  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> ($past(mode) != 2'b00));
  // R5
  empty_mask_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> ($past(en) != '0));
  // R1
  some_lane_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> ($past(lane_hit) != '0));

endmodule

// File: rtl/dvc_pair.sv
module dvc_pair
  import dvc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int W = DVC_LANES * BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_data,
  input  logic         bus_valid,
  input  logic [W-1:0] cmp_val_a,
  input  logic [W-1:0] cmp_val_b,
  input  logic [31:0]  ctrl_word,
  output logic         match_a,
  output logic         match_b
);
  // Control field positions, bit 0 = LSB.
  localparam int MODE_A_LO = 18;
  localparam int MODE_B_LO = 16;
  localparam int EN_A_TOP  = 11;
  localparam int EN_B_TOP  = 3;

  logic [1:0]           mode_a, mode_b;
  logic [DVC_LANES-1:0] en_a, en_b;

  assign mode_a = ctrl_word[MODE_A_LO +: 2];
  assign mode_b = ctrl_word[MODE_B_LO +: 2];

  // Highest bit of each enable field gates lane 0.
  for (genvar g = 0; g < DVC_LANES; g++) begin : g_en
    assign en_a[g] = ctrl_word[EN_A_TOP - g];
    assign en_b[g] = ctrl_word[EN_B_TOP - g];
  end

  dvc_unit #(.BYTE_W(BYTE_W)) unit_a_i (
    .clk (clk), .rst_n (rst_n), .valid (bus_valid), .data (bus_data),
    .ref_val (cmp_val_a), .mode (mode_a), .en (en_a), .match (match_a)
  );

  dvc_unit #(.BYTE_W(BYTE_W)) unit_b_i (
    .clk (clk), .rst_n (rst_n), .valid (bus_valid), .data (bus_data),
    .ref_val (cmp_val_b), .mode (mode_b), .en (en_b), .match (match_b)
  );

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!match_a && !match_b));

endmodule

// File: tb/dvc_pair_tb.sv
module dvc_pair_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_data, cmp_val_a, cmp_val_b, ctrl_word;
  logic        bus_valid;
  logic        match_a, match_b;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvc_pair dut_i (
    .clk (clk), .rst_n (rst_n), .bus_data (bus_data), .bus_valid (bus_valid),
    .cmp_val_a (cmp_val_a), .cmp_val_b (cmp_val_b), .ctrl_word (ctrl_word),
    .match_a (match_a), .match_b (match_b)
  );

  // Expected verdict from mode, mask and lane-hit pattern (bit i = lane i).
  function automatic bit expect_hit(input int mode, input int en, input int pat);
    int need_lo = en & 3;
    int need_hi = en & 12;
    case (mode)
      1: return (en != 0) && ((pat & en) == en);
      2: return (pat & en) != 0;
      3: return ((need_lo != 0) && ((pat & need_lo) == need_lo)) ||
                ((need_hi != 0) && ((pat & need_hi) == need_hi));
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int mode, input int en);
    if (mode == 0) return "R6";
    if (en == 0)   return "R5";
    if (mode == 1) return "R2";
    if (mode == 2) return "R3";
    return "R4";
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  // Lane i sits in bits [31-8i -: 8]; enable field bit (top - i) gates lane i.
  task automatic drive(input int ma, input int ea, input int pa,
                       input int mb, input int eb, input int pb);
    logic [31:0] ref_a = 32'hA5_3C_96_0F;
    logic [31:0] d, rb, cw;
    d  = ref_a;
    rb = ref_a;
    cw = '0;
    for (int i = 0; i < 4; i++) begin
      if (!pa[i]) d[31-8*i -: 8] = ref_a[31-8*i -: 8] ^ (8'h01 << i);
    end
    for (int i = 0; i < 4; i++) begin
      rb[31-8*i -: 8] = pb[i] ? d[31-8*i -: 8] : (d[31-8*i -: 8] ^ 8'h80);
      cw[11-i] = ea[i];
      cw[3-i]  = eb[i];
    end
    cw[19:18] = ma[1:0];
    cw[17:16] = mb[1:0];
    bus_data  = d;
    cmp_val_a = ref_a;
    cmp_val_b = rb;
    ctrl_word = cw;
  endtask

  initial begin
    rst_n = 1'b0;
    bus_valid = 1'b1;
    drive(1, 15, 15, 2, 15, 15);
    repeat (3) @(negedge clk);
    // R7: held low under reset even with a matching valid cycle
    chk(match_a, 1'b0, "R7 reset match_a");
    chk(match_b, 1'b0, "R7 reset match_b");
    rst_n = 1'b1;
    for (int ma = 0; ma < 4; ma++) begin
      for (int ea = 0; ea < 16; ea++) begin
        for (int pa = 0; pa < 16; pa++) begin
          int mb = 3 - ma;
          int eb = (~ea) & 15;
          int pb = pa ^ 5;
          drive(ma, ea, pa, mb, eb, pb);
          bus_valid = 1'b1;
          @(negedge clk);
          chk(match_a, expect_hit(ma, ea, pa),
              $sformatf("%s R1 R8 A mode=%0d en=%0h pat=%0h", tag_of(ma, ea), ma, ea, pa));
          chk(match_b, expect_hit(mb, eb, pb),
              $sformatf("%s R9 R8 B mode=%0d en=%0h pat=%0h", tag_of(mb, eb), mb, eb, pb));
          if (pa == 15) begin
            // R7: idle cycle with fully matching data must not pulse
            drive(1, 15, 15, 2, 15, 15);
            bus_valid = 1'b0;
            @(negedge clk);
            chk(match_a, 1'b0, "R7 idle match_a");
            chk(match_b, 1'b0, "R7 idle match_b");
          end
        end
      end
    end
    // R7: one valid cycle then idle gives a single-cycle pulse
    drive(1, 15, 15, 1, 15, 15);
    bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(match_a, 1'b1, "R7 pulse high");
    @(negedge clk);
    chk(match_a, 1'b0, "R7 pulse one cycle");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule